// File: doc/BRIEF.md
# Four-Phase Interpolating Pulse Shaper

This block turns a stream of I and Q symbols into a fourfold-oversampled, pulse-shaped stream for a QAM transmitter. A clock enable (`os_en`) marks each oversampled output slot. A phase counter steps through four slots per symbol. On the last slot of each symbol the block takes a new I and Q symbol into two 31-deep delay lines. In every slot, each branch multiplies the 31 stored symbols by the coefficient set of the current phase, sums the products and adds that phase's signed offset. An arithmetic right shift then reduces the result to a 10-bit output.

Both branches share the four coefficient sets, the four offsets and the shift setting. All of them are loaded one word per cycle through a small write port. The filter does not saturate, so choosing coefficients and a shift value that keep the result in range is left to whoever programs the block.

Top module: `qam_pulse_shaper`

## Requirements
- R1: While reset is asserted, and after it is released, `out_vld`, `out_i` and `out_q` are zero. Reset clears all coefficients and offsets to zero and the shift setting to 0, which selects the default shift of 5. Until something is written, every output is zero whatever symbols arrive.
- R2: `out_vld` is high in exactly the cycle that follows a cycle with `os_en` high. `out_i` and `out_q` change only in those cycles and hold their value otherwise.
- R3: The k-th enabled slot after reset (k = 0, 1, 2, ...) uses coefficient set and offset number k mod 4.
- R4: The delay lines advance only in an enabled slot of phase 3, taking in `sym_i` and `sym_q` at that edge. Tap t holds the symbol loaded t symbol periods before the most recent one (tap 0 is the newest). Symbol inputs in all other cycles are ignored.
- R5: The result of a slot is the sum over the 31 taps of symbol times coefficient, plus the 11-bit signed offset of that phase. All values are two's complement.
- R6: The result is arithmetically shifted right, rounding toward minus infinity. A shift setting N from 1 to 15 shifts by N, and a setting of 0 shifts by 5.
- R7: The output is the low 10 bits of the shifted result. Values that do not fit wrap around without saturation.
- R8: The Q branch uses the same coefficients, offsets and shift as the I branch, applied to its own symbol history.
- R9: A write with `wr_en` high takes effect at that clock edge. `wr_addr[7]`=0 selects the filter memory, with `wr_addr[6:5]` giving the phase. Within it, `wr_addr[4:0]` = 0..30 writes tap coefficient `wr_data[9:0]`, and `wr_addr[4:0]` = 31 writes the phase offset `wr_data[10:0]`. `wr_addr[7]`=1 writes the shift setting from `wr_data[3:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_en | input | 1 | Oversampled output slot enable |
| sym_i | input | 8 | I symbol, signed, sampled on phase-3 slots |
| sym_q | input | 8 | Q symbol, signed, sampled on phase-3 slots |
| wr_en | input | 1 | Write strobe for coefficients, offsets and shift |
| wr_addr | input | 8 | Write address: {cfg, phase[1:0], tap[4:0]} |
| wr_data | input | 11 | Write data, signed |
| out_vld | output | 1 | New output sample present |
| out_i | output | 10 | Shaped I sample, signed |
| out_q | output | 10 | Shaped Q sample, signed |

## Verification
A phase counter that slips or starts on the wrong value pairs every output with the wrong coefficient set. When each phase has distinct random coefficients and offsets, this corrupts the very next valid sample. A delay line that shifts on the wrong slot, or takes in symbols presented on non-load cycles, misaligns the history, and the error shows within one symbol period. A shift setting or offset that is decoded wrongly shows up as a mismatch in every following sample. To expose these faults, the bench sweeps all 16 shift settings, varies the spacing of the enables and drives deliberately junk symbols on the slots that must be ignored.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int NTAPS         = 31;
  localparam int NPHASE        = 4;
  localparam int DW            = 8;
  localparam int CW            = 10;
  localparam int OFW           = 11;
  localparam int ACCW          = 24;
  localparam int OW            = 10;
  localparam int SHW           = 4;
  localparam int SHIFT_DEFAULT = 5;
  localparam int PHW           = $clog2(NPHASE);
  localparam int TAPW          = $clog2(NTAPS + 1);
  localparam int ADDRW         = 1 + PHW + TAPW;
endpackage

// File: rtl/qps_sequencer.sv
module qps_sequencer #(
  parameter int NPHASE = qps_pkg::NPHASE,
  localparam int PHW   = $clog2(NPHASE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           os_en,
  output logic [PHW-1:0] phase,
  output logic           load_sym
);
  localparam logic [PHW-1:0] LAST = PHW'(NPHASE - 1);

  logic [PHW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (os_en) begin
      if (ph_q == LAST) ph_d = '0;
      else              ph_d = ph_q + PHW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase    = ph_q;
  assign load_sym = os_en && (ph_q == LAST);

  // R3: each enabled slot moves to the next phase, wrapping after the last
  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(os_en)) |->
      (phase == (($past(phase) == LAST) ? '0 : $past(phase) + PHW'(1))));

  // R3: no enable, no phase movement
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(os_en)) |-> $stable(phase));
endmodule

// File: rtl/qps_tap_line.sv
module qps_tap_line #(
  parameter int NTAPS = qps_pkg::NTAPS,
  parameter int DW    = qps_pkg::DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [DW-1:0]             din,
  output logic [NTAPS-1:0][DW-1:0]  taps
);
  logic [NTAPS-1:0][DW-1:0] line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (shift_en) line_d = {line_q[NTAPS-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign taps = line_q;

  // R4: history holds between symbol loads
  a_r4_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(shift_en)) |-> $stable(taps));

  // R4: on a load the newest sample lands in tap 0 and the rest move down
  a_r4_line_shift: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(shift_en)) |->
      (taps[0] == $past(din) && taps[1] == $past(taps[0])));
endmodule

// File: rtl/qps_coef_bank.sv
module qps_coef_bank #(
  parameter int NTAPS         = qps_pkg::NTAPS,
  parameter int NPHASE        = qps_pkg::NPHASE,
  parameter int CW            = qps_pkg::CW,
  parameter int OFW           = qps_pkg::OFW,
  parameter int SHW           = qps_pkg::SHW,
  parameter int SHIFT_DEFAULT = qps_pkg::SHIFT_DEFAULT,
  localparam int PHW          = $clog2(NPHASE),
  localparam int TAPW         = $clog2(NTAPS + 1),
  localparam int ADDRW        = 1 + PHW + TAPW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDRW-1:0]          wr_addr,
  input  logic [OFW-1:0]            wr_data,
  input  logic [PHW-1:0]            phase,
  output logic [NTAPS-1:0][CW-1:0]  coefs,
  output logic [OFW-1:0]            offset,
  output logic [SHW-1:0]            shift_eff
);
  logic [NPHASE-1:0][NTAPS-1:0][CW-1:0] coef_q, coef_d;
  logic [NPHASE-1:0][OFW-1:0]           offs_q, offs_d;
  logic [SHW-1:0]                       shift_q, shift_d;

  logic            is_cfg;
  logic [PHW-1:0]  w_ph;
  logic [TAPW-1:0] w_tap;

  assign is_cfg = wr_addr[ADDRW-1];
  assign w_ph   = wr_addr[TAPW +: PHW];
  assign w_tap  = wr_addr[TAPW-1:0];

  // per-entry write enables and next-state
  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    logic ph_hit;
    assign ph_hit = wr_en && !is_cfg && (w_ph == PHW'(p));
    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
      always_comb begin
        coef_d[p][t] = coef_q[p][t];
        if (ph_hit && (w_tap == TAPW'(t))) coef_d[p][t] = wr_data[CW-1:0];
      end
    end
    always_comb begin
      offs_d[p] = offs_q[p];
      if (ph_hit && (w_tap == TAPW'(NTAPS))) offs_d[p] = wr_data;
    end
  end

  always_comb begin
    shift_d = shift_q;
    if (wr_en && is_cfg) shift_d = wr_data[SHW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q  <= '0;
      offs_q  <= '0;
      shift_q <= '0;
    end else begin
      coef_q  <= coef_d;
      offs_q  <= offs_d;
      shift_q <= shift_d;
    end
  end

  // phase multiplexers feeding both branches
  assign coefs     = coef_q[phase];
  assign offset    = offs_q[phase];
  assign shift_eff = (shift_q == '0) ? SHW'(SHIFT_DEFAULT) : shift_q;

  // R6: the applied shift is never zero
  a_r6_shift_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    shift_eff != '0);

  // R9: a configuration write sets the shift seen by the datapath
  a_r9_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_cfg && wr_data[SHW-1:0] != '0) |=>
      (shift_eff == $past(wr_data[SHW-1:0])));
endmodule

// File: rtl/qps_mac.sv
module qps_mac #(
  parameter int NTAPS = qps_pkg::NTAPS,
  parameter int DW    = qps_pkg::DW,
  parameter int CW    = qps_pkg::CW,
  parameter int OFW   = qps_pkg::OFW,
  parameter int ACCW  = qps_pkg::ACCW,
  parameter int OW    = qps_pkg::OW,
  parameter int SHW   = qps_pkg::SHW,
  localparam int PW   = DW + CW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      os_en,
  input  logic [NTAPS-1:0][DW-1:0]  taps,
  input  logic [NTAPS-1:0][CW-1:0]  coefs,
  input  logic [OFW-1:0]            offset,
  input  logic [SHW-1:0]            shift_eff,
  output logic [OW-1:0]             y
);
  logic signed [PW-1:0]   prod [NTAPS];
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] total;
  logic signed [ACCW-1:0] scaled;
  logic [OW-1:0]          y_q, y_d;

  for (genvar t = 0; t < NTAPS; t++) begin : g_mul
    assign prod[t] = $signed(taps[t]) * $signed(coefs[t]);
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < NTAPS; t++) begin
      acc = acc + {{(ACCW-PW){prod[t][PW-1]}}, prod[t]};
    end
  end

  assign total  = acc + {{(ACCW-OFW){offset[OFW-1]}}, offset};
  assign scaled = total >>> shift_eff;

  always_comb begin
    y_d = y_q;
    if (os_en) y_d = scaled[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else        y_q <= y_d;
  end

  assign y = y_q;

  // R2: the output moves only after an enabled slot
  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(os_en)) |-> $stable(y));
endmodule

// File: rtl/qam_pulse_shaper.sv
module qam_pulse_shaper #(
  parameter int NTAPS         = qps_pkg::NTAPS,
  parameter int NPHASE        = qps_pkg::NPHASE,
  parameter int DW            = qps_pkg::DW,
  parameter int CW            = qps_pkg::CW,
  parameter int OFW           = qps_pkg::OFW,
  parameter int ACCW          = qps_pkg::ACCW,
  parameter int OW            = qps_pkg::OW,
  parameter int SHW           = qps_pkg::SHW,
  parameter int SHIFT_DEFAULT = qps_pkg::SHIFT_DEFAULT,
  localparam int PHW          = $clog2(NPHASE),
  localparam int TAPW         = $clog2(NTAPS + 1),
  localparam int ADDRW        = 1 + PHW + TAPW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_en,
  input  logic [DW-1:0]    sym_i,
  input  logic [DW-1:0]    sym_q,
  input  logic             wr_en,
  input  logic [ADDRW-1:0] wr_addr,
  input  logic [OFW-1:0]   wr_data,
  output logic             out_vld,
  output logic [OW-1:0]    out_i,
  output logic [OW-1:0]    out_q
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [PHW-1:0]            phase;
  logic                      load_sym;
  logic [NTAPS-1:0][CW-1:0]  coefs;
  logic [OFW-1:0]            offset;
  logic [SHW-1:0]            shift_eff;
  logic [1:0][DW-1:0]        sym_in;
  logic [1:0][OW-1:0]        y;
  logic                      vld_q, vld_d;

  assign sym_in[0] = sym_i;
  assign sym_in[1] = sym_q;

  qps_sequencer #(.NPHASE(NPHASE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s),
    .os_en    (os_en),
    .phase    (phase),
    .load_sym (load_sym)
  );

  qps_coef_bank #(
    .NTAPS(NTAPS), .NPHASE(NPHASE), .CW(CW), .OFW(OFW),
    .SHW(SHW), .SHIFT_DEFAULT(SHIFT_DEFAULT)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .phase     (phase),
    .coefs     (coefs),
    .offset    (offset),
    .shift_eff (shift_eff)
  );

  for (genvar b = 0; b < 2; b++) begin : g_branch
    logic [NTAPS-1:0][DW-1:0] taps;

    qps_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
      .clk      (clk),
      .rst_n    (rst_s),
      .shift_en (load_sym),
      .din      (sym_in[b]),
      .taps     (taps)
    );

    qps_mac #(
      .NTAPS(NTAPS), .DW(DW), .CW(CW), .OFW(OFW),
      .ACCW(ACCW), .OW(OW), .SHW(SHW)
    ) u_mac (
      .clk       (clk),
      .rst_n     (rst_s),
      .os_en     (os_en),
      .taps      (taps),
      .coefs     (coefs),
      .offset    (offset),
      .shift_eff (shift_eff),
      .y         (y[b])
    );
  end

  always_comb vld_d = os_en;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_vld = vld_q;
  assign out_i   = y[0];
  assign out_q   = y[1];

  // R2: a change on either output is always accompanied by out_vld
  a_r2_change_flagged: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && !out_vld) |-> ($stable(out_i) && $stable(out_q)));

  // R1: outputs are zero while the block is held in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_s |-> (!out_vld && out_i == '0 && out_q == '0));
endmodule

// File: tb/tb_qam_pulse_shaper.sv
module tb_qam_pulse_shaper;
  localparam int NT = 31;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        os_en;
  logic [7:0]  sym_i, sym_q;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [10:0] wr_data;
  logic        out_vld;
  logic [9:0]  out_i, out_q;

  always #5 clk = ~clk;

  qam_pulse_shaper dut (
    .clk(clk), .rst_n(rst_n), .os_en(os_en), .sym_i(sym_i), .sym_q(sym_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int errors = 0;

  // independent model state
  int hist [2][NT];
  int cf   [4][NT];
  int offv [4];
  int shv;
  int mph;
  logic [9:0] exp_i, exp_q;

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 2; b++) for (int t = 0; t < NT; t++) hist[b][t] = 0;
    for (int p = 0; p < 4; p++) begin
      offv[p] = 0;
      for (int t = 0; t < NT; t++) cf[p][t] = 0;
    end
    shv = 0; mph = 0; exp_i = '0; exp_q = '0;
  endtask

  function automatic logic [9:0] model(input int b, input int p);
    longint acc = 0;
    int sh;
    for (int t = 0; t < NT; t++) acc += longint'(hist[b][t]) * longint'(cf[p][t]);
    acc += offv[p];
    sh = (shv == 0) ? 5 : shv;
    acc = acc >>> sh;
    return acc[9:0];
  endfunction

  // R9: write helpers following the address map of the requirement
  task automatic wr_coef(input int p, input int t, input int v);
    wr_en = 1'b1; wr_addr = {1'b0, 2'(p), 5'(t)}; wr_data = 11'(v);
    @(negedge clk);
    wr_en = 1'b0;
    cf[p][t] = v;
  endtask

  task automatic wr_off(input int p, input int v);
    wr_en = 1'b1; wr_addr = {1'b0, 2'(p), 5'd31}; wr_data = 11'(v);
    @(negedge clk);
    wr_en = 1'b0;
    offv[p] = v;
  endtask

  task automatic wr_shift(input int v);
    wr_en = 1'b1; wr_addr = 8'h80; wr_data = 11'(v);
    @(negedge clk);
    wr_en = 1'b0;
    shv = v;
  endtask

  // one cycle: drive at the falling edge, check at the next falling edge
  task automatic step(input bit en, input int si, input int sq, input string tag);
    os_en = en; sym_i = 8'(si); sym_q = 8'(sq);
    if (en) begin
      exp_i = model(0, mph);
      exp_q = model(1, mph);
      if (mph == 3) begin
        for (int t = NT - 1; t > 0; t--) begin
          hist[0][t] = hist[0][t-1];
          hist[1][t] = hist[1][t-1];
        end
        hist[0][0] = si; hist[1][0] = sq;
      end
      mph = (mph + 1) % 4;
    end
    @(negedge clk);
    os_en = 1'b0;
    chk({"R2 out_vld ", tag}, int'(out_vld), int'(en));
    chk({"out_i ", tag}, int'(out_i), int'(exp_i));
    chk({"R8 out_q ", tag}, int'(out_q), int'(exp_q));
  endtask

  function automatic int rsym();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    os_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    sym_i = 8'h5a; sym_q = 8'ha5;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs clear while reset is held
    chk("R1 vld in reset", int'(out_vld), 0);
    chk("R1 out_i in reset", int'(out_i), 0);
    chk("R1 out_q in reset", int'(out_q), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 vld after reset", int'(out_vld), 0);
    chk("R1 out_i after reset", int'(out_i), 0);
    chk("R1 out_q after reset", int'(out_q), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual %0d cycles expected fewer", 200000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R1: zero coefficients give zero output for any symbols
    for (int k = 0; k < 16; k++) step(1'b1, rsym(), rsym(), "R1 zero bank");

    // R3 R4: distinct per-phase ramps, impulse through the line, shift 1
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < NT; t++) wr_coef(p, t, (p * 97 + t * 13) % 1000 - 500);
      wr_off(p, 0);
    end
    wr_shift(1);
    for (int k = 0; k < 4 * 34; k++) begin
      int si, sq;
      // R4: junk on non-load slots must be ignored
      si = (mph == 3) ? ((k == 3) ? 100 : 0) : rsym();
      sq = (mph == 3) ? ((k == 3) ? -77 : 0) : rsym();
      step(1'b1, si, sq, "R3 R4 impulse");
    end

    // R5 R6 R7: random coefficients and offsets, every shift setting
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 4; p++) begin
        for (int t = 0; t < NT; t++) wr_coef(p, t, int'($urandom_range(0, 1023)) - 512);
        wr_off(p, int'($urandom_range(0, 2047)) - 1024);
      end
      wr_shift(s);
      for (int k = 0; k < 40; k++) begin
        bit en;
        en = (s[0]) ? 1'b1 : bit'(k % 3 != 1);
        step(en, rsym(), rsym(), "R5 R6 sweep");
      end
    end

    // R7: extreme magnitudes wrap without saturation
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < NT; t++) wr_coef(p, t, -512);
      wr_off(p, (p[0]) ? 1023 : -1024);
    end
    for (int s = 1; s < 4; s++) begin
      wr_shift(s);
      for (int k = 0; k < 4 * 33; k++) step(1'b1, -128, 127, "R7 wrap");
    end

    // R1: a second reset returns to the empty bank and default shift
    do_reset();
    for (int k = 0; k < 12; k++) step(1'b1, rsym(), rsym(), "R1 after re-reset");
    wr_coef(0, 0, 320);
    for (int k = 0; k < 12; k++) step(1'b1, 90, -90, "R6 default shift");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule